// File: doc/BRIEF.md
# Power Island Sequencer

This block switches one peripheral power island off and on through timed sequences, under the control of a small memory-mapped register file. Software programs two delay fields for each direction, optionally enables gating, and then sets one request bit in the control register. The controller drives an isolation enable and a power-switch enable in the required order. It holds the final step back by the sum of the two delays for that direction, counted in bus clock cycles.

When the island goes down, isolation is applied first and the switch opens last. When it comes up, the switch closes first and isolation is released last. The request bit reads back as set while its sequence runs and clears itself when the sequence ends. Two read-only status bits report busy and powered. Software can treat the island as settled once the programmed delay sum has elapsed.

Top module: `island_power_seq`

## Requirements
- R1: After reset, the isolation output is 0, the switch output is 1, and the control register (offset 0x000) reads 0x8. The gating, power-up timing and power-down timing registers read 0.
- R2: Register readback works as follows. The gating register at 0x260 keeps bit 0. The power-up timing register at 0x264 and the power-down timing register at 0x268 keep bits [5:0] (first delay) and [13:8] (second delay). All other bits, and all unmapped offsets, read 0.
- R3: A write of bit 0 to the control register when gating is enabled starts a power-down. Isolation rises at the accepting clock edge. The switch opens exactly N cycles later, where N is the sum of the two power-down fields. At that same edge, busy and request bit 0 clear.
- R4: A write of bit 1 to the control register starts a power-up. The switch closes at the accepting edge. Isolation is released exactly N cycles later, where N is the sum of the two power-up fields. At that same edge, busy and request bit 1 clear.
- R5: When the delay sum for the requested direction is 0, the sequence completes at the accepting edge, and busy is never seen high.
- R6: A power-down request while gating bit 0 is 0 completes at once. The island stays powered and isolation stays released.
- R7: If one write sets both request bits, only the power-up runs.
- R8: Writes to the control register while a sequence is running are ignored. The running sequence keeps its direction and length, and no other sequence follows it.
- R9: The switch is never open while isolation is released.
- R10: Control register bit 2 reads busy. Bit 3 reads powered, which is defined as the switch closed and isolation released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all delays count its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| iso_en | output | 1 | Isolation enable towards the island |
| sw_on | output | 1 | Power-switch enable towards the island |

## Verification
The first step of a sequence (isolation for a power-down, switch for a power-up) and the start of busy appear right after the edge that accepts the write. The closing step and the clearing of the request bit come exactly the programmed delay sum of edges later. The bench drives each write across one rising edge and samples at the following falling edge. From there it counts falling edges until the closing output changes, and compares that count against the sum of the two fields it programmed. Ignored, gated-off and zero-delay requests are checked at the first falling edge after the write, together with the control register value.

// File: rtl/island_power_seq.sv
`timescale 1ns/1ps
module island_power_seq #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DLY_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              iso_en,
  output logic              sw_on
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'('h260);
  localparam logic [ADDR_W-1:0] A_UPT  = ADDR_W'('h264);
  localparam logic [ADDR_W-1:0] A_DNT  = ADDR_W'('h268);
  localparam int HI = 8;
  localparam int CW = DLY_W + 1;

  logic             gate_en, run_up, run_dn;
  logic [DLY_W-1:0] up_a, up_b, dn_a, dn_b;
  logic [CW-1:0]    cnt, up_sum, dn_sum;
  logic             busy, powered, ctrl_wr;
  logic             unused_wdata_bits;

  assign busy    = run_up | run_dn;
  assign powered = sw_on & ~iso_en;
  assign ctrl_wr = bus_we && bus_addr == A_CTRL;
  assign up_sum  = {1'b0, up_a} + {1'b0, up_b};
  assign dn_sum  = {1'b0, dn_a} + {1'b0, dn_b};
  assign unused_wdata_bits = ^{bus_wdata[DATA_W-1:HI+DLY_W], bus_wdata[HI-1:DLY_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_en <= 1'b0;
      up_a <= '0; up_b <= '0; dn_a <= '0; dn_b <= '0;
      run_up <= 1'b0; run_dn <= 1'b0; cnt <= '0;
      iso_en <= 1'b0; sw_on <= 1'b1;
    end else begin
      if (bus_we) begin
        case (bus_addr)
          A_GATE: gate_en <= bus_wdata[0];
          A_UPT: begin up_a <= bus_wdata[DLY_W-1:0]; up_b <= bus_wdata[HI+DLY_W-1:HI]; end
          A_DNT: begin dn_a <= bus_wdata[DLY_W-1:0]; dn_b <= bus_wdata[HI+DLY_W-1:HI]; end
          default: ;
        endcase
      end
      if (busy) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          if (run_dn) sw_on <= 1'b0;
          else        iso_en <= 1'b0;
          run_up <= 1'b0;
          run_dn <= 1'b0;
        end
      end else if (ctrl_wr) begin
        if (bus_wdata[1]) begin
          sw_on <= 1'b1;
          if (up_sum == '0) iso_en <= 1'b0;
          else begin run_up <= 1'b1; cnt <= up_sum; end
        end else if (bus_wdata[0] && gate_en) begin
          iso_en <= 1'b1;
          if (dn_sum == '0) sw_on <= 1'b0;
          else begin run_dn <= 1'b1; cnt <= dn_sum; end
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[3:0] = {powered, busy, run_up, run_dn};
      A_GATE: bus_rdata[0] = gate_en;
      A_UPT: begin bus_rdata[DLY_W-1:0] = up_a; bus_rdata[HI+DLY_W-1:HI] = up_b; end
      A_DNT: begin bus_rdata[DLY_W-1:0] = dn_a; bus_rdata[HI+DLY_W-1:HI] = dn_b; end
      default: ;
    endcase
  end

  p_open_only_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_on |-> iso_en);
  p_release_needs_power_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> sw_on);
  p_one_direction_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({run_up, run_dn}));
  p_outputs_hold_mid_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(iso_en) && $stable(sw_on)));
  p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr && cnt != CW'(1)) |=> ($stable(run_up) && $stable(run_dn)));
endmodule

// File: tb/island_power_seq_test.sv
`timescale 1ns/1ps
module island_power_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        iso_en, sw_on;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  island_power_seq uut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .iso_en(iso_en), .sw_on(sw_on));

  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic count_until(bit watch_sw, output int n);
    n = 0;
    while ((watch_sw ? sw_on : iso_en) == 1'b1 && n < 300) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h000, v); check("R1 ctrl", v, 32'h8);
    check("R1 iso", iso_en, 0); check("R1 sw", sw_on, 1);
    rd(12'h260, v); check("R1 gate", v, 0);
    rd(12'h264, v); check("R1 upt", v, 0);
    rd(12'h268, v); check("R1 dnt", v, 0);

    wr(12'h264, 32'hFFFF_FFFF); rd(12'h264, v); check("R2 upt mask", v, 32'h3F3F);
    wr(12'h268, 32'h0000_2A15); rd(12'h268, v); check("R2 dnt", v, 32'h2A15);
    wr(12'h260, 32'hFFFF_FFFF); rd(12'h260, v); check("R2 gate mask", v, 32'h1);
    rd(12'h123, v); check("R2 unmapped", v, 0);

    wr(12'h260, 0);
    wr(12'h268, 32'h0303);
    wr(12'h000, 1);
    rd(12'h000, v); check("R6 ctrl after gated-off request", v, 32'h8);
    check("R6 sw", sw_on, 1); check("R6 iso", iso_en, 0);
    wr(12'h260, 1);

    for (int t = 0; t < 27; t++) begin
      int a, b;
      a = (t < 25) ? t % 5 : 63;
      b = (t < 25) ? t / 5 : 63 * (26 - t);
      wr(12'h268, (b << 8) | a);
      wr(12'h264, (a << 8) | b);
      wr(12'h000, 1);
      check("R3 iso raised", iso_en, 1);
      rd(12'h000, v);
      check("R3/R10 ctrl during down", v, (a + b == 0) ? 32'h0 : 32'h5);
      if (a + b == 0) check("R5 down immediate", sw_on, 0);
      count_until(1'b1, n);
      check("R3 down length", n, a + b);
      rd(12'h000, v); check("R3/R10 ctrl after down", v, 0);
      wr(12'h000, 2);
      check("R4 sw closed", sw_on, 1);
      rd(12'h000, v);
      check("R4/R10 ctrl during up", v, (a + b == 0) ? 32'h8 : 32'h6);
      count_until(1'b0, n);
      check("R4 up length", n, a + b);
      rd(12'h000, v); check("R4/R10 ctrl after up", v, 32'h8);
    end

    wr(12'h268, 32'h0A0A);
    wr(12'h264, 32'h0204);
    wr(12'h000, 1);
    @(negedge clk); @(negedge clk);
    wr(12'h000, 2);
    rd(12'h000, v); check("R8 busy write ignored", v, 32'h5);
    count_until(1'b1, n);
    check("R8 down length kept", n, 20 - 3);
    repeat (10) @(negedge clk);
    check("R8 no follow-on up", sw_on, 0);
    rd(12'h000, v); check("R8 ctrl idle down", v, 0);

    wr(12'h000, 3);
    rd(12'h000, v); check("R7 both bits runs up", v, 32'h6);
    count_until(1'b0, n);
    check("R7 up length", n, 6);
    check("R7 sw", sw_on, 1);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(negedge clk); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule